// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates between a parameterised set of interrupt sources and a single CPU request line. Every source owns a pending flag, an enable bit, a 5-bit priority and a 32-bit vector offset, all reached through a word-addressed register port. The flag and enable words and the priority words each have a clear alias and a set alias next to the plain address, so software can change single bits without a read-modify-write. The control word holds one edge-polarity bit for each external pin.

Two capture styles exist. A persistent (level) source keeps its flag high for as long as its request line is high, so software can only retire it once the peripheral has dropped the line. A non-persistent (edge) source latches a rising edge, and a clear always removes it. The external pins are edge sources whose active edge is chosen in the control word. Each cycle the block picks the pending, enabled source with the largest priority value and registers the result. That result drives the CPU request, the winner number and the winner's vector offset.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all flags, enables, priorities, polarity bits and vector offsets read 0, `cpuReq` is 0, `winId` is 0 and the status word (byte address 0x020) reads 0.
- R2: The flag word for source n is at 0x040 + (n/32)*0x10 and the enable word is at 0x0C0 + (n/32)*0x10. Source n uses bit n%32 of its word, and a plain write followed by a read returns the written value.
- R3: For the flag, enable, priority and control words, address+4 clears every bit written as 1 and address+8 sets every bit written as 1. Bits written as 0 keep their value, and the change is visible on the next cycle.
- R4: The priority of source n is held in bits (n%4)*8+4 down to (n%4)*8 of the word at 0x140 + (n/4)*0x10. The top three bits of each byte always read 0.
- R5: The vector offset of source n is a 32-bit read/write word at 0x540 + n*4. `winVecOff` shows the winner's offset while `cpuReq` is 1 and shows 0 otherwise.
- R6: A level source sets its flag in every cycle in which its request is high, and a clear has no effect during that time. Once the request has dropped the flag stays at 1 until it is cleared.
- R7: An edge source sets its flag on a 0-to-1 change of its request. A clear removes the flag even while the request is still high, and the flag stays at 0 until the next rising edge.
- R8: External pin k drives source EXT_BASE+k. Control bit k+1 set to 1 selects the rising edge and set to 0 selects the falling edge. Only control bits 1 to NUM_EXT are stored and all other control bits read 0.
- R9: The winner is the pending, enabled source with the largest 5-bit priority value, and when priorities are equal the lower source number wins.
- R10: A source whose priority is 0 or whose enable bit is 0 never wins.
- R11: `cpuReq`, `winId` and status bits 7:0 show the winner one cycle after the flag, enable and priority state that selects it. When there is no winner, `cpuReq` is 0 and `winId` and the status word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| srcReq | input | NUM_SRC | Request line of each source (ignored for the external-pin sources) |
| extPin | input | NUM_EXT | External interrupt pins |
| cpuReq | output | 1 | Interrupt request to the CPU |
| winId | output | 8 | Number of the winning source |
| winVecOff | output | 32 | Vector offset of the winning source |

## Verification
The assertions assume that the request lines and pins are synchronous to `clk` and change at most once per cycle. They also assume that the external pins are low when reset is released, because the pin history resets to 0 and a pin that is high at that moment looks like a rising edge. The bench drives every input on the falling edge and keeps the pins low through reset. Each register access targets one mapped address per cycle. The winner check compares against the flag, enable and priority state of the previous cycle, so it relies on the winner register being the only stage between that state and `cpuReq`.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int IDX_W     = 8;
  localparam int CTRL_BASE = 32'h000;
  localparam int STAT_BASE = 32'h020;
  localparam int FLAG_BASE = 32'h040;
  localparam int EN_BASE   = 32'h0C0;
  localparam int PRI_BASE  = 32'h140;
  localparam int VEC_BASE  = 32'h540;

  typedef enum logic [2:0] {
    BANK_NONE, BANK_CTRL, BANK_STAT, BANK_FLAG, BANK_EN, BANK_PRI, BANK_VEC
  } bank_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0, OP_CLEAR = 2'd1, OP_SET = 2'd2
  } op_e;

  typedef struct packed {
    logic             wrStrobe;
    bank_e            bank;
    op_e              op;
    logic [IDX_W-1:0] index;
  } reg_strobe_t;

  function automatic logic [31:0] applyOp(input logic [31:0] oldVal,
                                          input logic [31:0] wrVal,
                                          input op_e op);
    case (op)
      OP_CLEAR: applyOp = oldVal & ~wrVal;
      OP_SET:   applyOp = oldVal | wrVal;
      default:  applyOp = wrVal;
    endcase
  endfunction
endpackage

// File: rtl/prio_irq_decode.sv
module prio_irq_decode
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output reg_strobe_t       strobe
);
  localparam int BIT_WORDS = NUM_SRC / 32;
  localparam int PRI_WORDS = NUM_SRC / 4;

  int   addrInt;
  logic aliasOk;
  op_e  aliasOp;

  always_comb begin
    addrInt = int'(regAddr);
    aliasOk = regAddr[3:2] != 2'd3;
    case (regAddr[3:2])
      2'd1:    aliasOp = OP_CLEAR;
      2'd2:    aliasOp = OP_SET;
      default: aliasOp = OP_WRITE;
    endcase
    strobe.bank  = BANK_NONE;
    strobe.op    = aliasOp;
    strobe.index = '0;
    if (addrInt < CTRL_BASE + 16) begin
      if (aliasOk) strobe.bank = BANK_CTRL;
    end else if (addrInt >= STAT_BASE && addrInt < STAT_BASE + 4) begin
      strobe.bank = BANK_STAT;
    end else if (addrInt >= FLAG_BASE && addrInt < FLAG_BASE + BIT_WORDS * 16) begin
      if (aliasOk) strobe.bank = BANK_FLAG;
      strobe.index = IDX_W'((addrInt - FLAG_BASE) / 16);
    end else if (addrInt >= EN_BASE && addrInt < EN_BASE + BIT_WORDS * 16) begin
      if (aliasOk) strobe.bank = BANK_EN;
      strobe.index = IDX_W'((addrInt - EN_BASE) / 16);
    end else if (addrInt >= PRI_BASE && addrInt < PRI_BASE + PRI_WORDS * 16) begin
      if (aliasOk) strobe.bank = BANK_PRI;
      strobe.index = IDX_W'((addrInt - PRI_BASE) / 16);
    end else if (addrInt >= VEC_BASE && addrInt < VEC_BASE + NUM_SRC * 4) begin
      strobe.bank  = BANK_VEC;
      strobe.op    = OP_WRITE;
      strobe.index = IDX_W'((addrInt - VEC_BASE) / 4);
    end
    strobe.wrStrobe = regWr && (strobe.bank != BANK_NONE) && (strobe.bank != BANK_STAT);
  end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]      cand,
  input  logic [NUM_SRC-1:0][4:0] priVec,
  output logic                    found,
  output logic [7:0]              bestIdx
);
  logic [4:0] bestPri;

  // Ascending scan with strict compare: a tie keeps the lower number and
  // priority 0 can never beat the initial best of 0.
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestPri = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && priVec[i] > bestPri) begin
        found   = 1'b1;
        bestPri = priVec[i];
        bestIdx = 8'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int                 NUM_SRC    = 64,
  parameter int                 NUM_EXT    = 8,
  parameter int                 EXT_BASE   = 48,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  reg_strobe_t             strobe,
  input  logic [31:0]             wrData,
  input  logic [NUM_SRC-1:0]      srcReq,
  input  logic [NUM_EXT-1:0]      extPin,
  output logic [31:0]             rdData,
  output logic [NUM_SRC-1:0]      flagVec,
  output logic [NUM_SRC-1:0]      enVec,
  output logic [NUM_SRC-1:0][4:0] priVec,
  output logic                    cpuReq,
  output logic [7:0]              winId,
  output logic [31:0]             winVecOff
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]      flagQ, flagNext, enQ, reqPrevQ;
  logic [NUM_SRC-1:0][4:0] priQ;
  logic [31:0]             vecQ [NUM_SRC];
  logic [NUM_EXT-1:0]      polQ, extPrevQ;
  logic                    winValidQ, arbFound;
  logic [7:0]              winIdxQ, arbIdx;
  logic [31:0]             ctrlOld, ctrlNew, enOld, enNew, flagOld, flagNew, priOld, priNew;
  int                      idx;

  always_comb begin
    idx     = int'(strobe.index);
    ctrlOld = '0;
    ctrlOld[NUM_EXT:1] = polQ;
    enOld   = enQ[idx*32 +: 32];
    flagOld = flagQ[idx*32 +: 32];
    priOld  = '0;
    for (int j = 0; j < 4; j++) priOld[j*8 +: 5] = priQ[idx*4 + j];
    ctrlNew = applyOp(ctrlOld, wrData, strobe.op);
    enNew   = applyOp(enOld, wrData, strobe.op);
    flagNew = applyOp(flagOld, wrData, strobe.op);
    priNew  = applyOp(priOld, wrData, strobe.op);
  end

  // Flag capture: hardware set always wins over a software clear.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_flag
    localparam int  WORD   = n / 32;
    localparam int  BITPOS = n % 32;
    localparam bit  IS_EXT = (n >= EXT_BASE) && (n < EXT_BASE + NUM_EXT);
    logic hwHit, swHit;
    if (IS_EXT) begin : g_ext
      localparam int K = n - EXT_BASE;
      assign hwHit = polQ[K] ? (extPin[K] & ~extPrevQ[K]) : (~extPin[K] & extPrevQ[K]);
    end else if (LEVEL_MASK[n]) begin : g_level
      assign hwHit = srcReq[n];
    end else begin : g_edge
      assign hwHit = srcReq[n] & ~reqPrevQ[n];
    end
    assign swHit = strobe.wrStrobe && strobe.bank == BANK_FLAG && int'(strobe.index) == WORD;
    assign flagNext[n] = hwHit | (swHit ? flagNew[BITPOS] : flagQ[n]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= '0;
      reqPrevQ <= '0;
      extPrevQ <= '0;
    end else begin
      flagQ    <= flagNext;
      reqPrevQ <= srcReq;
      extPrevQ <= extPin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ <= '0;
      enQ  <= '0;
      priQ <= '0;
    end else if (strobe.wrStrobe) begin
      case (strobe.bank)
        BANK_CTRL: polQ <= ctrlNew[NUM_EXT:1];
        BANK_EN:   enQ[idx*32 +: 32] <= enNew;
        BANK_PRI:  for (int j = 0; j < 4; j++) priQ[idx*4 + j] <= priNew[j*8 +: 5];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_SRC; v++) vecQ[v] <= '0;
    end else if (strobe.wrStrobe && strobe.bank == BANK_VEC) begin
      vecQ[strobe.index[SRC_W-1:0]] <= wrData;
    end
  end

  prio_irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .cand    (flagQ & enQ),
    .priVec  (priQ),
    .found   (arbFound),
    .bestIdx (arbIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winValidQ <= 1'b0;
      winIdxQ   <= '0;
    end else begin
      winValidQ <= arbFound;
      winIdxQ   <= arbFound ? arbIdx : 8'd0;
    end
  end

  always_comb begin
    case (strobe.bank)
      BANK_CTRL: rdData = ctrlOld;
      BANK_STAT: rdData = {24'd0, winIdxQ};
      BANK_FLAG: rdData = flagOld;
      BANK_EN:   rdData = enOld;
      BANK_PRI:  rdData = priOld;
      BANK_VEC:  rdData = vecQ[strobe.index[SRC_W-1:0]];
      default:   rdData = '0;
    endcase
  end

  assign flagVec   = flagQ;
  assign enVec     = enQ;
  assign priVec    = priQ;
  assign cpuReq    = winValidQ;
  assign winId     = winIdxQ;
  assign winVecOff = winValidQ ? vecQ[winIdxQ[SRC_W-1:0]] : 32'd0;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int                 NUM_SRC    = 64,
  parameter int                 NUM_EXT    = 8,
  parameter int                 EXT_BASE   = 48,
  parameter int                 ADDR_W     = 12,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'(32'h0000_00FF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_EXT-1:0] extPin,
  output logic               cpuReq,
  output logic [7:0]         winId,
  output logic [31:0]        winVecOff
);
  reg_strobe_t             strobe;
  logic [NUM_SRC-1:0]      flagVec, enVec;
  logic [NUM_SRC-1:0][4:0] priVec;

  prio_irq_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .regWr   (regWr),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  prio_irq_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .EXT_BASE(EXT_BASE), .LEVEL_MASK(LEVEL_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .srcReq    (srcReq),
    .extPin    (extPin),
    .rdData    (regRdData),
    .flagVec   (flagVec),
    .enVec     (enVec),
    .priVec    (priVec),
    .cpuReq    (cpuReq),
    .winId     (winId),
    .winVecOff (winVecOff)
  );
endmodule

// File: rtl/prio_irq_ctrl_checker.sv
module prio_irq_ctrl_checker #(
  parameter int                 NUM_SRC    = 64,
  parameter int                 NUM_EXT    = 8,
  parameter int                 EXT_BASE   = 48,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cpuReq,
  input logic [7:0]              winId,
  input logic [NUM_SRC-1:0]      srcReq,
  input logic [NUM_SRC-1:0]      flagVec,
  input logic [NUM_SRC-1:0]      enVec,
  input logic [NUM_SRC-1:0][4:0] priVec
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic                    armed;
  logic [NUM_SRC-1:0]      prevFlag, prevEn, prevReq, levelOnly;
  logic [NUM_SRC-1:0][4:0] prevPri;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_lvl
    assign levelOnly[n] = LEVEL_MASK[n] && !((n >= EXT_BASE) && (n < EXT_BASE + NUM_EXT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      prevFlag <= '0;
      prevEn   <= '0;
      prevReq  <= '0;
      prevPri  <= '0;
    end else begin
      armed    <= 1'b1;
      prevFlag <= flagVec;
      prevEn   <= enVec;
      prevReq  <= srcReq;
      prevPri  <= priVec;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!cpuReq && winId == 8'd0));

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((prevReq & levelOnly & ~flagVec) == '0));

  assert_winner_eligible_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (prevFlag[winId[SRC_W-1:0]] && prevEn[winId[SRC_W-1:0]] &&
                prevPri[winId[SRC_W-1:0]] != 5'd0));

  assert_idle_zero_id_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |-> winId == 8'd0);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker #(
  .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .EXT_BASE(EXT_BASE), .LEVEL_MASK(LEVEL_MASK)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .winId   (winId),
  .srcReq  (srcReq),
  .flagVec (flagVec),
  .enVec   (enVec),
  .priVec  (priVec)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NUM_SRC = 64;
  localparam int NUM_EXT = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWr = 1'b0;
  logic [11:0]        regAddr = '0;
  logic [31:0]        regWrData = '0;
  logic [31:0]        regRdData;
  logic [NUM_SRC-1:0] srcReq = '0;
  logic [NUM_EXT-1:0] extPin = '0;
  logic               cpuReq;
  logic [7:0]         winId;
  logic [31:0]        winVecOff;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .srcReq(srcReq), .extPin(extPin), .cpuReq(cpuReq),
    .winId(winId), .winVecOff(winVecOff)
  );

  // pri20, pri21, pri40, pri41, enable {41,40,21,20}, expected request, expected winner
  localparam logic [32:0] ARB_TBL [10] = '{
    {5'd5,  5'd3,  5'd1,  5'd2,  4'b1111, 1'b1, 8'd20},
    {5'd3,  5'd5,  5'd1,  5'd2,  4'b1111, 1'b1, 8'd21},
    {5'd1,  5'd1,  5'd1,  5'd1,  4'b1111, 1'b1, 8'd20},
    {5'd0,  5'd1,  5'd1,  5'd1,  4'b1111, 1'b1, 8'd21},
    {5'd31, 5'd31, 5'd31, 5'd31, 4'b1100, 1'b1, 8'd40},
    {5'd4,  5'd4,  5'd9,  5'd9,  4'b1010, 1'b1, 8'd41},
    {5'd0,  5'd0,  5'd0,  5'd0,  4'b1111, 1'b0, 8'd0},
    {5'd7,  5'd8,  5'd8,  5'd2,  4'b0000, 1'b0, 8'd0},
    {5'd12, 5'd16, 5'd16, 5'd31, 4'b0111, 1'b1, 8'd21},
    {5'd1,  5'd0,  5'd2,  5'd3,  4'b0001, 1'b1, 8'd20}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 cpuReq", {31'd0, cpuReq}, 32'd0);
    check("R1 winId", {24'd0, winId}, 32'd0);
    check("R1 winVecOff", winVecOff, 32'd0);
    regRead(12'h020, rd); check("R1 status", rd, 32'd0);
    regRead(12'h000, rd); check("R1 control", rd, 32'd0);
    regRead(12'h050, rd); check("R1 flag word1", rd, 32'd0);
    regRead(12'h0D0, rd); check("R1 enable word1", rd, 32'd0);
    regRead(12'h140, rd); check("R1 priority word0", rd, 32'd0);
    regRead(12'h550, rd); check("R1 vector 4", rd, 32'd0);

    // Arbitration table over sources 20, 21 (word0) and 40, 41 (word1)
    regWrite(12'h590, 32'h1014); regWrite(12'h594, 32'h1015);
    regWrite(12'h5E0, 32'h1028); regWrite(12'h5E4, 32'h1029);
    regWrite(12'h048, 32'h0030_0000);
    regWrite(12'h058, 32'h0000_0300);
    for (int v = 0; v < 10; v++) begin
      logic [32:0] e;
      e = ARB_TBL[v];
      regWrite(12'h190, {16'd0, 3'd0, e[27:23], 3'd0, e[32:28]});
      regWrite(12'h1E0, {16'd0, 3'd0, e[17:13], 3'd0, e[22:18]});
      regWrite(12'h0C0, {10'd0, e[10], e[9], 20'd0});
      regWrite(12'h0D0, {22'd0, e[12], e[11], 8'd0});
      repeat (2) @(negedge clk);
      check($sformatf("R9 R10 vector %0d cpuReq", v), {31'd0, cpuReq}, {31'd0, e[8]});
      check($sformatf("R9 R11 vector %0d winId", v), {24'd0, winId}, {24'd0, e[7:0]});
      check($sformatf("R5 vector %0d winVecOff", v), winVecOff,
            e[8] ? (32'h1000 + {24'd0, e[7:0]}) : 32'd0);
    end
    regWrite(12'h0C0, 32'd0);
    regWrite(12'h0D0, 32'd0);

    // R2 / R3 enable word access and aliases
    regWrite(12'h0D0, 32'hA5A5_0000);
    regRead(12'h0D0, rd); check("R2 enable plain", rd, 32'hA5A5_0000);
    regWrite(12'h0D4, 32'h0500_0000);
    regRead(12'h0D0, rd); check("R3 enable clear alias", rd, 32'hA0A5_0000);
    regWrite(12'h0D8, 32'h0000_000F);
    regRead(12'h0D0, rd); check("R3 enable set alias", rd, 32'hA0A5_000F);
    regWrite(12'h0D0, 32'd0);

    // R4 priority packing
    regWrite(12'h140, 32'hFFFF_FFFF);
    regRead(12'h140, rd); check("R4 priority byte mask", rd, 32'h1F1F_1F1F);
    regWrite(12'h144, 32'h0000_1F00);
    regRead(12'h140, rd); check("R4 R3 priority clear alias", rd, 32'h1F1F_001F);
    regWrite(12'h140, 32'd0);

    // R5 vector offset read/write
    regWrite(12'h54C, 32'hDEAD_BEEF);
    regRead(12'h54C, rd); check("R5 vector 3", rd, 32'hDEAD_BEEF);

    // R6 level source 2
    srcReq[2] = 1'b1;
    regRead(12'h040, rd); check("R6 level set", rd & 32'h4, 32'h4);
    regWrite(12'h044, 32'h4);
    regRead(12'h040, rd); check("R6 clear ignored while high", rd & 32'h4, 32'h4);
    srcReq[2] = 1'b0;
    regRead(12'h040, rd); regRead(12'h040, rd);
    check("R6 sticky after drop", rd & 32'h4, 32'h4);
    regWrite(12'h044, 32'h4);
    regRead(12'h040, rd); check("R6 clear after drop", rd & 32'h4, 32'h0);

    // R7 edge source 30
    srcReq[30] = 1'b1;
    regRead(12'h040, rd); check("R7 edge set", rd & 32'h4000_0000, 32'h4000_0000);
    regWrite(12'h044, 32'h4000_0000);
    regRead(12'h040, rd); check("R7 clear while high", rd & 32'h4000_0000, 32'h0);
    regRead(12'h040, rd); check("R7 no re-set while high", rd & 32'h4000_0000, 32'h0);
    srcReq[30] = 1'b0;

    // R8 external pin 0 -> source 48, flag word1 bit16
    extPin[0] = 1'b1;
    regRead(12'h050, rd); check("R8 falling mode ignores rise", rd & 32'h1_0000, 32'h0);
    extPin[0] = 1'b0;
    regRead(12'h050, rd); check("R8 falling mode sets", rd & 32'h1_0000, 32'h1_0000);
    regWrite(12'h054, 32'h1_0000);
    regWrite(12'h008, 32'h2);
    regRead(12'h000, rd); check("R8 R3 control set alias", rd, 32'h2);
    extPin[0] = 1'b1;
    regRead(12'h050, rd); check("R8 rising mode sets", rd & 32'h1_0000, 32'h1_0000);
    regWrite(12'h054, 32'h1_0000);
    extPin[0] = 1'b0;
    regRead(12'h050, rd); check("R8 rising mode ignores fall", rd & 32'h1_0000, 32'h0);
    regWrite(12'h000, 32'hFFFF_FFFF);
    regRead(12'h000, rd); check("R8 control stored bits", rd, 32'h0000_01FE);
    regWrite(12'h000, 32'd0);

    // R11 latency: source 33 (word1 bit1), priority word 8 byte1
    regWrite(12'h1C0, 32'h0000_0A00);
    regWrite(12'h0D8, 32'h2);
    repeat (2) @(negedge clk);
    check("R11 idle before flag", {31'd0, cpuReq}, 32'd0);
    regWrite(12'h058, 32'h2);
    check("R11 not yet requested", {31'd0, cpuReq}, 32'd0);
    @(negedge clk);
    check("R11 request one cycle later", {31'd0, cpuReq}, 32'd1);
    check("R11 winner id", {24'd0, winId}, 32'd33);
    regRead(12'h020, rd); check("R11 status winner", rd, 32'd33);
    regWrite(12'h054, 32'h2);
    repeat (2) @(negedge clk);
    check("R11 request drops", {31'd0, cpuReq}, 32'd0);
    regRead(12'h020, rd); check("R11 status idle", rd, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule